// File: doc/BRIEF.md
# Handshaked Control-Register Bus Sequencer

This block is a hardware master for a narrow control-register bus of the kind used to program PHY lane settings. The bus has one shared data-in word that carries either an address or write data, one data-out word from the far end, four separate strobe lines (address capture, data capture, read, write) and a single acknowledge line. Every bus phase is a full four-phase handshake. The value is presented first with no strobe. Then the strobe rises, the master waits for acknowledge high, drops the strobe and waits for acknowledge low.

The local side issues one command at a time: read, write, or update. An update is a read-modify-write. A read runs an address phase and a read phase. A write runs an address phase, a data phase and a write phase. An update runs a complete read followed by a complete write to the same address. The written value is the old value with the mask bits cleared, ORed with the supplied value. Each acknowledge wait is bounded by a cycle-count timeout. When it expires, the transaction is abandoned and reported as an error.

Top module: `crbus_seq`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o, done_o and err_o are low, all four strobes are low, and bus_din_o and rdata_o are zero.
- R2: At most one of bus_cap_addr_o, bus_cap_data_o, bus_rd_o and bus_wr_o is high in any cycle.
- R3: Before any strobe rises, the phase value is on bus_din_o with no strobe high for at least SETUP_CYC cycles (default 2). The value is then held unchanged while the strobe is high.
- R4: A strobe stays high until bus_ack_i is seen high, and only then falls (a timeout excepted). The next phase begins only after bus_ack_i has been seen low.
- R5: A read (cmd_op_i = 0) produces exactly two strobe phases: address capture carrying the address, then read with bus_din_o at zero. rdata_o takes the bus_dout_i value present when acknowledge is seen high in the read phase.
- R6: A write (cmd_op_i = 1) produces exactly three phases: address capture with the address, then data capture with the data, then the write strobe with the data still on bus_din_o.
- R7: An update (cmd_op_i[1] = 1, so codes 2 and 3) produces five phases in this order: address, read, address, data, write. The data written is (old & ~cmd_mask_i) | cmd_data_i, and rdata_o shows the old value.
- R8: If bus_ack_i does not reach the expected level within TIMEOUT_CYC cycles of waiting, all strobes drop. err_o pulses for one cycle while busy_o is already low, done_o does not pulse, and a strobe left waiting for acknowledge high has been high exactly TIMEOUT_CYC cycles. The next command runs normally.
- R9: A command is accepted only in a cycle with cmd_valid_i high and busy_o low. busy_o is high in the following cycle. cmd_valid_i while busy_o is high is ignored and starts no bus activity.
- R10: On success done_o pulses for exactly one cycle, with busy_o already low. rdata_o is cleared to zero when a command is accepted and is otherwise held until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 or 3 update |
| cmd_addr_i | input | DW | Register address |
| cmd_data_i | input | DW | Write data or value to OR in |
| cmd_mask_i | input | DW | Bits to clear on update |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| rdata_o | output | DW | Data from the last read phase |
| bus_din_o | output | DW | Address or data to the far end |
| bus_cap_addr_o | output | 1 | Address capture strobe |
| bus_cap_data_o | output | 1 | Data capture strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_dout_i | input | DW | Read data from the far end |
| bus_ack_i | input | 1 | Handshake acknowledge |

## Verification
The assertions check the cycle-level bus discipline on every cycle. They cover strobe exclusivity, a value that is stable as a strobe rises, strobe release only after acknowledge or on error, a zero data word during reads, single-cycle done and error pulses, and rdata held while idle. Only the bench scenarios can show the phase order and values of each command type, the read-modify-write arithmetic, and the exact timeout length. They also show that commands offered while busy leave the far-end registers untouched, and that the block recovers after both kinds of timeout.

// File: rtl/crbus_pkg.sv
package crbus_pkg;
  // kind value is also the strobe index
  typedef enum logic [1:0] {
    K_ADDR  = 2'd0,
    K_DATA  = 2'd1,
    K_READ  = 2'd2,
    K_WRITE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    P_IDLE, P_SETUP, P_HIGH, P_LOW
  } pstate_e;

  typedef enum logic [2:0] {
    C_IDLE, C_ADDR1, C_RD, C_ADDR2, C_DATA, C_WR
  } cstate_e;

  localparam int unsigned NUM_STRB = 4;
endpackage

// File: rtl/crbus_ack_timer.sv
module crbus_ack_timer #(
  parameter int unsigned TIMEOUT_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic restart_i,
  output logic tmo_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] cnt_q;

  assign tmo_o = wait_i && (cnt_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!wait_i || restart_i) begin
      cnt_q <= '0;
    end else if (!tmo_o) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/crbus_phase.sv
module crbus_phase import crbus_pkg::*; #(
  parameter int unsigned DW        = 16,
  parameter int unsigned SETUP_CYC = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  kind_e               kind_i,
  input  logic [DW-1:0]       value_i,
  input  logic                ack_i,
  input  logic                tmo_i,
  output logic [DW-1:0]       din_o,
  output logic [NUM_STRB-1:0] strb_o,
  output logic                idle_o,
  output logic                wait_o,
  output logic                cap_o,
  output logic                pdone_o,
  output logic                perr_o
);
  localparam int unsigned SW = $clog2(SETUP_CYC + 1);

  pstate_e       st_q;
  kind_e         kind_q;
  logic [DW-1:0] val_q;
  logic [SW-1:0] scnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_IDLE;
      kind_q <= K_ADDR;
      val_q  <= '0;
      scnt_q <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (start_i) begin
          st_q   <= P_SETUP;
          kind_q <= kind_i;
          val_q  <= value_i;
          scnt_q <= '0;
        end
        P_SETUP: begin
          if (scnt_q == SW'(SETUP_CYC - 1)) st_q <= P_HIGH;
          else scnt_q <= scnt_q + SW'(1);
        end
        P_HIGH: begin
          if (ack_i) st_q <= P_LOW;
          else if (tmo_i) st_q <= P_IDLE;
        end
        P_LOW: if (!ack_i || tmo_i) st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign din_o   = (st_q == P_IDLE) ? '0 : val_q;
  assign idle_o  = (st_q == P_IDLE);
  assign wait_o  = (st_q == P_HIGH) || (st_q == P_LOW);
  assign cap_o   = (st_q == P_HIGH) && ack_i;
  assign pdone_o = (st_q == P_LOW) && !ack_i;
  assign perr_o  = tmo_i && (((st_q == P_HIGH) && !ack_i) || ((st_q == P_LOW) && ack_i));

  for (genvar k = 0; k < NUM_STRB; k++) begin : g_strb
    assign strb_o[k] = (st_q == P_HIGH) && (kind_q == kind_e'(k));
  end
endmodule

// File: rtl/crbus_ctrl.sv
module crbus_ctrl import crbus_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [DW-1:0] cmd_mask_i,
  input  logic          phase_idle_i,
  input  logic          cap_i,
  input  logic          pdone_i,
  input  logic          perr_i,
  input  logic [DW-1:0] dout_i,
  output logic          start_o,
  output kind_e         kind_o,
  output logic [DW-1:0] value_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  cstate_e       st_q, nxt;
  logic [DW-1:0] addr_q, wdata_q, mask_q, rdata_q;
  logic          upd_q, wr_q, done_q, err_q;

  always_comb begin
    case (st_q)
      C_ADDR1: nxt = wr_q ? C_DATA : C_RD;
      C_RD:    nxt = upd_q ? C_ADDR2 : C_IDLE;
      C_ADDR2: nxt = C_DATA;
      C_DATA:  nxt = C_WR;
      default: nxt = C_IDLE;
    endcase
  end

  always_comb begin
    kind_o  = K_ADDR;
    value_o = addr_q;
    case (st_q)
      C_RD:   begin kind_o = K_READ;  value_o = '0;      end
      C_DATA: begin kind_o = K_DATA;  value_o = wdata_q; end
      C_WR:   begin kind_o = K_WRITE; value_o = wdata_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= C_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      upd_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st_q == C_IDLE) begin
        if (cmd_valid_i) begin
          st_q    <= C_ADDR1;
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_data_i;
          mask_q  <= cmd_mask_i;
          upd_q   <= cmd_op_i[1];
          wr_q    <= !cmd_op_i[1] && cmd_op_i[0];
          rdata_q <= '0;
        end
      end else begin
        if (cap_i && (st_q == C_RD)) begin
          rdata_q <= dout_i;
          wdata_q <= (dout_i & ~mask_q) | wdata_q;
        end
        if (perr_i) begin
          st_q  <= C_IDLE;
          err_q <= 1'b1;
        end else if (pdone_i) begin
          st_q <= nxt;
          if (nxt == C_IDLE) done_q <= 1'b1;
        end
      end
    end
  end

  assign start_o = (st_q != C_IDLE) && phase_idle_i;
  assign busy_o  = (st_q != C_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/crbus_seq.sv
module crbus_seq import crbus_pkg::*; #(
  parameter int unsigned DW          = 16,
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned TIMEOUT_CYC = 250000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [DW-1:0] cmd_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] bus_din_o,
  output logic          bus_cap_addr_o,
  output logic          bus_cap_data_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  input  logic [DW-1:0] bus_dout_i,
  input  logic          bus_ack_i
);
  logic                start, phase_idle, wait_s, cap, pdone, perr, tmo;
  kind_e               kind;
  logic [DW-1:0]       value;
  logic [NUM_STRB-1:0] strb;

  crbus_ctrl #(.DW(DW)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_data_i   (cmd_data_i),
    .cmd_mask_i   (cmd_mask_i),
    .phase_idle_i (phase_idle),
    .cap_i        (cap),
    .pdone_i      (pdone),
    .perr_i       (perr),
    .dout_i       (bus_dout_i),
    .start_o      (start),
    .kind_o       (kind),
    .value_o      (value),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o)
  );

  crbus_phase #(.DW(DW), .SETUP_CYC(SETUP_CYC)) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .kind_i  (kind),
    .value_i (value),
    .ack_i   (bus_ack_i),
    .tmo_i   (tmo),
    .din_o   (bus_din_o),
    .strb_o  (strb),
    .idle_o  (phase_idle),
    .wait_o  (wait_s),
    .cap_o   (cap),
    .pdone_o (pdone),
    .perr_o  (perr)
  );

  crbus_ack_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_i    (wait_s),
    .restart_i (cap),
    .tmo_o     (tmo)
  );

  assign bus_cap_addr_o = strb[K_ADDR];
  assign bus_cap_data_o = strb[K_DATA];
  assign bus_rd_o       = strb[K_READ];
  assign bus_wr_o       = strb[K_WRITE];
endmodule

// File: rtl/crbus_seq_chk.sv
module crbus_seq_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] bus_din_o,
  input logic          bus_cap_addr_o,
  input logic          bus_cap_data_o,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic          bus_ack_i
);
  logic any_strb;
  assign any_strb = bus_cap_addr_o | bus_cap_data_o | bus_rd_o | bus_wr_o;

  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_wr_o, bus_rd_o, bus_cap_data_o, bus_cap_addr_o}));

  assert_value_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_strb) |-> $stable(bus_din_o));

  assert_hold_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strb && $past(any_strb)) |-> $stable(bus_din_o));

  assert_release_after_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_strb) |-> ($past(bus_ack_i) || err_o));

  assert_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |-> (bus_din_o == '0));

  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !any_strb && !done_o));

  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(rdata_o));
endmodule

bind crbus_seq crbus_seq_chk #(.DW(DW)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .rdata_o        (rdata_o),
  .bus_din_o      (bus_din_o),
  .bus_cap_addr_o (bus_cap_addr_o),
  .bus_cap_data_o (bus_cap_data_o),
  .bus_rd_o       (bus_rd_o),
  .bus_wr_o       (bus_wr_o),
  .bus_ack_i      (bus_ack_i)
);

// File: tb/test_crbus_seq.sv
`timescale 1ns/1ps
module test_crbus_seq;
  localparam int DW = 16, SETUP = 2, TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [DW-1:0] cmd_addr = '0, cmd_data = '0, cmd_mask = '0;
  logic          busy, done, err;
  logic [DW-1:0] rdata, din, bus_dout;
  logic          s_ca, s_cd, s_rd, s_wr, bus_ack;

  crbus_seq #(.DW(DW), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) i_crbus_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_mask_i(cmd_mask),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .bus_din_o(din), .bus_cap_addr_o(s_ca), .bus_cap_data_o(s_cd),
    .bus_rd_o(s_rd), .bus_wr_o(s_wr), .bus_dout_i(bus_dout), .bus_ack_i(bus_ack));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // far end model and bus monitor
  logic [15:0] rmem [16];
  logic [15:0] exp_mem [16];
  logic [15:0] r_addr = '0, r_data = '0;
  int ack_dly = 0, rel_dly = 0, rsp_mode = 0, dcnt = 0;
  int nlog = 0, scnt = 0, hicnt = 0;
  int log_kind [8], log_val [8], log_setup [8], log_hi [8];
  logic prev_any = 1'b0;
  logic [15:0] prev_din = '0;

  function automatic int kind_of(input logic [3:0] s);
    case (s)
      4'b0001: return 0;
      4'b0010: return 1;
      4'b0100: return 2;
      4'b1000: return 3;
      default: return 7;
    endcase
  endfunction

  task automatic act_on_ack();
    if (s_ca) r_addr = din;
    if (s_cd) r_data = din;
    if (s_wr) rmem[r_addr[3:0]] = r_data;
    if (s_rd) bus_dout = rmem[r_addr[3:0]];
  endtask

  initial begin
    bus_ack = 1'b0;
    bus_dout = '0;
    for (int i = 0; i < 16; i++) rmem[i] = '0;
    forever begin
      @(negedge clk);
      begin
        logic any;
        any = s_ca | s_cd | s_rd | s_wr;
        if (any && !prev_any && nlog < 8) begin
          log_kind[nlog]  = kind_of({s_wr, s_rd, s_cd, s_ca});
          log_val[nlog]   = int'(din);
          log_setup[nlog] = scnt;
          nlog++;
          hicnt = 0;
        end
        if (any) hicnt++;
        else begin
          if (prev_any && nlog > 0) log_hi[nlog-1] = hicnt;
          scnt = (din == prev_din && !prev_any) ? scnt + 1 : 1;
        end
        prev_any = any;
        prev_din = din;
        case (rsp_mode)
          0: begin
            if (any && !bus_ack) begin
              if (dcnt >= ack_dly) begin bus_ack = 1'b1; act_on_ack(); dcnt = 0; end
              else dcnt++;
            end else if (!any && bus_ack) begin
              if (dcnt >= rel_dly) begin bus_ack = 1'b0; dcnt = 0; end
              else dcnt++;
            end else dcnt = 0;
          end
          1: bus_ack = 1'b0;
          default: if (any && !bus_ack) begin bus_ack = 1'b1; act_on_ack(); end
        endcase
      end
    end
  end

  // res: 1 done, 2 error, 0 hung
  task automatic run_cmd(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                         input logic [15:0] m, input bit spam, output int res);
    res = 0;
    @(negedge clk);
    nlog = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_mask = m;
    @(negedge clk);
    check("R9 busy after accept", busy, 1);
    if (spam) begin
      cmd_op = 2'd1; cmd_addr = 16'h100C; cmd_data = 16'hDEAD;
      repeat (4) @(negedge clk);
    end
    cmd_valid = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      if (done || err) break;
      @(negedge clk);
    end
    if (done) res = 1;
    else if (err) res = 2;
    if (res != 0) begin
      check("R10 busy low at end", busy, 0);
      check("R8 no done with err", done & err, 0);
      @(negedge clk);
      check("R10 single cycle pulse", done | err, 0);
    end
  endtask

  task automatic check_setups(input string tag);
    for (int k = 0; k < nlog; k++) check(tag, log_setup[k] >= SETUP, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int res;
    logic [15:0] a, d, m, nv, old;
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done/err", {done, err}, 0);
    check("R1 reset strobes", {s_ca, s_cd, s_rd, s_wr}, 0);
    check("R1 reset din", din, 0);
    check("R1 reset rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {busy, done, err, s_ca, s_cd, s_rd, s_wr}, 0);

    // writes over all 16 registers, varied ack timing
    for (int i = 0; i < 16; i++) begin
      ack_dly = i % 4; rel_dly = (i / 4) % 3;
      a = 16'h1000 | 16'(i);
      d = 16'(i * 16'h1357) ^ 16'hA5C3;
      exp_mem[i] = d;
      run_cmd(2'd1, a, d, 16'h0, 0, res);
      check("R6 write done", res, 1);
      check("R6 phase count", nlog, 3);
      check("R6 kinds", {log_kind[0][3:0], log_kind[1][3:0], log_kind[2][3:0]}, 12'h013);
      check("R6 addr value", log_val[0], a);
      check("R6 data value", log_val[1], d);
      check("R6 write value", log_val[2], d);
      check("R6 far end reg", rmem[i], d);
      check("R10 rdata cleared by write", rdata, 0);
      check_setups("R3 setup cycles");
    end

    // reads back
    for (int i = 0; i < 16; i++) begin
      ack_dly = (i + 1) % 4; rel_dly = i % 3;
      a = 16'h1000 | 16'(i);
      run_cmd(2'd0, a, 16'hFFFF, 16'h0, 0, res);
      check("R5 read done", res, 1);
      check("R5 phase count", nlog, 2);
      check("R5 kinds", {log_kind[0][3:0], log_kind[1][3:0]}, 8'h02);
      check("R5 addr value", log_val[0], a);
      check("R5 din zero in read", log_val[1], 0);
      check("R5 rdata", rdata, exp_mem[i]);
      check_setups("R3 setup cycles");
      repeat (3) @(negedge clk);
      check("R10 rdata held", rdata, exp_mem[i]);
    end

    // updates, op 2 and 3
    for (int i = 0; i < 16; i++) begin
      ack_dly = i % 3; rel_dly = (i + 2) % 4;
      a = 16'h1000 | 16'(i);
      m = 16'hF00F << (i % 8);
      d = 16'(i * 16'h0421) & 16'h3C3C;
      old = exp_mem[i];
      nv = (old & ~m) | d;
      exp_mem[i] = nv;
      run_cmd((i % 2 == 0) ? 2'd2 : 2'd3, a, d, m, 0, res);
      check("R7 update done", res, 1);
      check("R7 phase count", nlog, 5);
      check("R7 kinds", {log_kind[0][3:0], log_kind[1][3:0], log_kind[2][3:0],
                         log_kind[3][3:0], log_kind[4][3:0]}, 20'h02013);
      check("R7 addr values", {log_val[0][15:0], log_val[2][15:0]}, {a, a});
      check("R7 read din zero", log_val[1], 0);
      check("R7 merged data", {log_val[3][15:0], log_val[4][15:0]}, {nv, nv});
      check("R7 far end reg", rmem[i], nv);
      check("R7 rdata old", rdata, old);
      check_setups("R3 setup cycles");
    end

    // command offered while busy must be ignored
    ack_dly = 1; rel_dly = 1;
    exp_mem[3] = 16'h0F0F;
    run_cmd(2'd1, 16'h1003, 16'h0F0F, 16'h0, 1, res);
    check("R9 write done", res, 1);
    check("R9 only own phases", nlog, 3);
    @(negedge clk);
    check("R9 no second start", busy, 0);
    check("R9 far end reg 12 untouched", rmem[12], exp_mem[12]);
    run_cmd(2'd0, 16'h100C, 16'h0, 16'h0, 0, res);
    check("R9 readback reg 12", rdata, exp_mem[12]);
    check("R9 reg 3 written", rmem[3], 16'h0F0F);

    // timeout waiting for ack high
    rsp_mode = 1;
    run_cmd(2'd0, 16'h1001, 16'h0, 16'h0, 0, res);
    check("R8 err on silent far end", res, 2);
    check("R8 one phase", nlog, 1);
    check("R8 strobe high length", log_hi[0], TMO);
    check("R8 strobes low", {s_ca, s_cd, s_rd, s_wr}, 0);

    // timeout waiting for ack low
    rsp_mode = 2;
    run_cmd(2'd1, 16'h1002, 16'h1234, 16'h0, 0, res);
    check("R8 err on stuck ack", res, 2);
    check("R8 stuck one phase", nlog, 1);
    check("R8 stuck strobes low", {s_ca, s_cd, s_rd, s_wr, busy}, 0);
    check("R8 reg 2 unchanged", rmem[2], exp_mem[2]);
    rsp_mode = 0; ack_dly = 0; rel_dly = 0;
    repeat (4) @(negedge clk);

    // recovery
    run_cmd(2'd0, 16'h1005, 16'h0, 16'h0, 0, res);
    check("R8 recovery read", res, 1);
    check("R8 recovery data", rdata, exp_mem[5]);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule